// File: doc/BRIEF.md
# Feedback-Programmed Modulus Counter

This block is a four-bit presettable up counter whose cycle length is set by feeding a decode of its own state back into its load or clear path. It can count through fewer than sixteen states without a separate modulus register. Three feedback schemes are available. The first reloads a preset value once the count reaches a programmed end state. The second reloads the preset once the counter reaches all ones. The third returns the counter to zero when the next count would equal a programmed decode value.

In the two reload schemes, the state that triggers the reload is visible on the count output for one full clock period before the reload takes effect. In the clear scheme, the decode is folded into the next-state logic, so the counter goes straight from the last wanted state to zero and never shows the decoded value. As a result, the clear scheme's decode value equals the number of states in the cycle. A one-cycle wrap pulse marks the clock period whose closing edge returns the counter to the start of its cycle. Integrators use the wrap pulse as a divided-clock strobe or as the enable for a following stage.

Top module: `modulus_counter`

## Requirements
- R1: A synchronous active-high `rst` sets `count` to 0000 on the next rising edge in every mode, and `wrap` is 0 while `rst` is high.
- R2: `mode` is decoded as 2'b00 reload-at-end, 2'b01 reload-at-all-ones, 2'b10 clear-at-decode; 2'b11 behaves exactly like 2'b00.
- R3: When no feedback event applies, `count` increases by one per rising edge, going from 1111 to 0000.
- R4: In mode 2'b00, when `count` equals `end_val` the next edge loads `preset`, so the end state is shown for exactly one cycle; preset/end pairs 0000/1011, 0001/1100 and 0100/1111 each give a twelve-state cycle.
- R5: In mode 2'b01, when `count` is 1111 the next edge loads `preset` and `end_val` has no effect; with preset 0100 the cycle has twelve states and with preset 1001 it has seven.
- R6: In mode 2'b10, when `count`+1 (modulo 16) equals `end_val` the next edge sets `count` to 0000, so `end_val` never appears on `count` and the cycle length equals `end_val`: twelve for 1100, eleven for 1011 and sixteen for 0000.
- R7: `wrap` is 1 exactly during the cycles whose closing edge performs a reload or a clear from the feedback logic, and 0 in all other cycles.
- R8: `preset` and `end_val` act on the cycle in which they are presented; a change takes effect on the next decode or reload without any extra delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Feedback scheme select |
| preset | input | 4 | Value loaded by the reload schemes |
| end_val | input | 4 | End state (reload scheme) or decode value (clear scheme) |
| count | output | 4 | Current counter state |
| wrap | output | 1 | High in the cycle whose edge returns the counter to its start |

## Verification
`count` is a register, so its value is due one rising edge after the inputs that determine it. `wrap` is a combinational decode of the present count and inputs, so it is due in the same cycle the inputs are applied. The driver changes inputs on the falling edge and queues the expected count and wrap for that same cycle. The monitor samples shortly after the falling edge, when both values are settled, so every check compares against the state produced by the preceding rising edge. Cycle lengths are measured between two observed wrap pulses and compared against the modulus each requirement names.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

    // Feedback scheme selected on the mode input.
    typedef enum logic [1:0] {
        FB_RELOAD_END   = 2'b00,
        FB_RELOAD_CARRY = 2'b01,
        FB_CLEAR_DECODE = 2'b10,
        FB_RELOAD_ALT   = 2'b11
    } fb_mode_e;

    // Control handed from the feedback decoder to the counter core.
    typedef struct packed {
        logic reload;
        logic clear;
    } fb_ctl_t;

    // True for the schemes that reload the preset.
    function automatic logic uses_reload(input fb_mode_e m);
        return (m != FB_CLEAR_DECODE);
    endfunction

endpackage

// File: rtl/mc_feedback.sv
module mc_feedback
    import modcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  fb_mode_e          mode,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  end_val,
    output fb_ctl_t           ctl,
    output logic              event_o
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic             terminal;
    logic [CNT_W-1:0] successor;

    assign terminal  = &count;
    assign successor = count + STEP;

    always_comb begin
        ctl = '0;
        unique case (mode)
            FB_RELOAD_END,
            FB_RELOAD_ALT:   ctl.reload = (count == end_val);
            FB_RELOAD_CARRY: ctl.reload = terminal;
            FB_CLEAR_DECODE: ctl.clear  = (successor == end_val);
            default:         ctl = '0;
        endcase
    end

    assign event_o = ctl.reload | ctl.clear;

    // R2: exactly one kind of action per scheme; never both at once.
    always_comb begin
        assert_single_action_R2: assert ($onehot0({ctl.reload, ctl.clear}))
            else $error("reload and clear raised together");
    end

endmodule

// File: rtl/mc_core.sv
module mc_core
    import modcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  fb_ctl_t           ctl,
    input  logic [CNT_W-1:0]  preset,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)             count <= '0;
        else if (ctl.clear)  count <= '0;
        else if (ctl.reload) count <= preset;
        else                 count <= count + STEP;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> count == '0)
        else $error("count not zero after reset");

    assert_increment_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clear && !ctl.reload) |=> count == $past(count) + STEP)
        else $error("count did not advance by one");

endmodule

// File: rtl/modulus_counter.sv
module modulus_counter
    import modcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  preset,
    input  logic [CNT_W-1:0]  end_val,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    fb_mode_e mode_e;
    fb_ctl_t  ctl;
    logic     fb_event;

    assign mode_e = fb_mode_e'(mode);

    mc_feedback #(.CNT_W(CNT_W)) u_feedback (
        .mode    (mode_e),
        .count   (count),
        .end_val (end_val),
        .ctl     (ctl),
        .event_o (fb_event)
    );

    mc_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .preset (preset),
        .count  (count)
    );

    assign wrap = fb_event & ~rst;

    assert_reload_preset_R4: assert property (@(posedge clk) disable iff (rst)
        (wrap && uses_reload(mode_e)) |=> count == $past(preset))
        else $error("reload did not copy preset");

    assert_carry_state_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap && mode_e == FB_RELOAD_CARRY) |-> &count)
        else $error("carry reload away from all ones");

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (wrap && mode_e == FB_CLEAR_DECODE) |=> count == '0)
        else $error("clear scheme did not return to zero");

    assert_no_wrap_in_reset_R1: assert property (@(posedge clk)
        rst |-> !wrap)
        else $error("wrap high during reset");

endmodule

// File: tb/tb_modulus_counter.sv
`timescale 1ns/100ps
module tb_modulus_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [3:0] preset = 4'd0;
    logic [3:0] end_val = 4'd15;
    logic [3:0] count;
    logic       wrap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int    q_cnt[$];
    bit    q_wrap[$];
    string q_tag[$];

    logic [3:0] exp_cnt = 4'd0;

    always #2.5 clk = ~clk;

    modulus_counter dut (
        .clk(clk), .rst(rst), .mode(mode), .preset(preset),
        .end_val(end_val), .count(count), .wrap(wrap)
    );

    // Expected feedback event from the requirements (R2, R4, R5, R6).
    function automatic bit exp_event(input logic [1:0] m, input logic [3:0] c,
                                     input logic [3:0] e);
        case (m)
            2'b01:   return (c == 4'hF);
            2'b10:   return (4'(c + 4'd1) == e);
            default: return (c == e);
        endcase
    endfunction

    // One cycle: drive inputs at the falling edge, queue expectation, sample wrap.
    task automatic drive_cycle(input logic r, input logic [1:0] m,
                               input logic [3:0] p, input logic [3:0] e,
                               input string tag, output bit w_seen);
        bit ev;
        @(negedge clk);
        rst = r; mode = m; preset = p; end_val = e;
        ev = r ? 1'b0 : exp_event(m, exp_cnt, e);
        q_cnt.push_back(int'(exp_cnt));
        q_wrap.push_back(ev);
        q_tag.push_back(tag);
        if (r)          exp_cnt = 4'd0;
        else if (ev)    exp_cnt = (m == 2'b10) ? 4'd0 : p;
        else            exp_cnt = exp_cnt + 4'd1;
        #1;
        w_seen = wrap;
    endtask

    task automatic run(input int n, input logic [1:0] m, input logic [3:0] p,
                       input logic [3:0] e, input string tag);
        bit w;
        for (int i = 0; i < n; i++) drive_cycle(1'b0, m, p, e, tag, w);
    endtask

    task automatic measure(input logic [1:0] m, input logic [3:0] p,
                           input logic [3:0] e, input int want, input string tag);
        bit w;
        int n;
        w = 1'b0;
        for (int i = 0; i < 40 && !w; i++) drive_cycle(1'b0, m, p, e, tag, w);
        n = 0;
        w = 1'b0;
        for (int i = 0; i < 40 && !w; i++) begin
            drive_cycle(1'b0, m, p, e, tag, w);
            n++;
        end
        n_checks++;
        if (n != want) begin
            n_fail++;
            $display("FAIL %s cycle length actual %0d expected %0d", tag, n, want);
        end
    endtask

    // Monitor: pop and compare each queued cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q_cnt.size() > 0) begin
                int    c;
                bit    w;
                string t;
                c = q_cnt.pop_front();
                w = q_wrap.pop_front();
                t = q_tag.pop_front();
                n_checks++;
                if (int'(count) !== c) begin
                    n_fail++;
                    $display("FAIL %s count actual %0d expected %0d", t, count, c);
                end
                n_checks++;
                if (wrap !== w) begin
                    n_fail++;
                    $display("FAIL %s wrap actual %0b expected %0b", t, wrap, w);
                end
            end
        end
    end

    initial begin
        bit w;
        repeat (2) @(posedge clk);
        exp_cnt = 4'd0;
        // R1: reset state, then R3 free count through the 1111 -> 0000 rollover
        drive_cycle(1'b0, 2'b01, 4'd0, 4'd0, "R1 reset state", w);
        run(20, 2'b00, 4'd0, 4'd15, "R3 plain count");
        // R4 reload-at-end pairs
        measure(2'b00, 4'd0, 4'd11, 12, "R4 p0 e11");
        run(14, 2'b00, 4'd0, 4'd11, "R4 p0 e11 sequence");
        measure(2'b00, 4'd1, 4'd12, 12, "R4 p1 e12");
        measure(2'b00, 4'd4, 4'd15, 12, "R4 p4 e15");
        // R5 carry reload; end_val varied to show it is ignored
        measure(2'b01, 4'd4, 4'd3, 12, "R5 p4");
        measure(2'b01, 4'd9, 4'd9, 7, "R5 p9");
        // R6 clear at decode
        measure(2'b10, 4'd7, 4'd12, 12, "R6 e12");
        measure(2'b10, 4'd7, 4'd11, 11, "R6 e11");
        measure(2'b10, 4'd7, 4'd0, 16, "R6 e0");
        // R2 mode 2'b11 behaves as reload-at-end
        measure(2'b11, 4'd2, 4'd5, 4, "R2 alt mode");
        // R8 preset changed mid-run takes effect at next reload
        run(3, 2'b00, 4'd3, 4'd8, "R8 preset a");
        run(12, 2'b00, 4'd6, 4'd8, "R8 preset b");
        measure(2'b00, 4'd6, 4'd8, 3, "R8 new modulus");
        // R1 mid-run reset in each mode, R7 wrap checked throughout
        run(5, 2'b01, 4'd8, 4'd0, "R7 carry run");
        drive_cycle(1'b1, 2'b01, 4'd8, 4'd0, "R1 reset mode01", w);
        drive_cycle(1'b1, 2'b10, 4'd8, 4'd1, "R1 reset held", w);
        run(6, 2'b10, 4'd8, 4'd3, "R7 clear run");
        drive_cycle(1'b1, 2'b00, 4'd0, 4'd0, "R1 reset at end state", w);
        run(4, 2'b00, 4'd5, 4'd2, "R1 after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule